// File: doc/BRIEF.md
# Scanout Address Commit Unit

This unit holds the pair of addresses a display fetch engine uses to read a frame, the first byte of the visible window and its ceiling, and decides in which frame a newly requested buffer takes effect. Each flip request carries a buffer base, a plane offset, a line pitch, a pan position, a pixel size in bytes and an active line count. The unit turns these into a start and a ceiling address and presents both to the fetch engine as one 64-bit word. That word changes only on a frame-start pulse, so the fetch engine never sees a start from one buffer with a ceiling from another.

The unit keeps a microsecond timestamp of the last end-of-frame and the programmed refresh rate. From these it predicts the next vertical blank. A flip that arrives too close to that blank, or after it, is parked and applied at the next end-of-frame. A flip that arrives earlier goes straight into the shadow pair. Every accepted flip opens a completion event. The event closes with a one-cycle pulse at an end-of-frame, but not at the end-of-frame that applied a parked flip. While an event is open, further flips are refused with a busy indication. Dropping the enable discards everything: the parked flip, the current buffer, the open event and the timestamp.

Top module: `scanout_commit`

## Requirements
- R1: The start address is base + plane offset + pan_y × pitch + pan_x × bytes-per-pixel, taken modulo 2^32.
- R2: The ceiling is start + lines × pitch − 1 when parameter CEIL_LAST_BYTE is 1 (the default), and start + lines × pitch when it is 0.
- R3: `dma_pair` carries the ceiling in bits 63:32 and the start in bits 31:0. It is 0 after reset and changes only in the cycle after a `frame_start` pulse sampled while enabled, when it copies the shadow pair as a whole.
- R4: When no end-of-frame timestamp exists (value 0) or `refresh_hz` is 0, an accepted flip is written to the shadow pair at once and `flip_deferred` stays 0.
- R5: Let next = last timestamp + 1,000,000 / refresh_hz, and d = next − `us_now` taken as a signed 32-bit value. If d < SAFE_US (default 1000), including when d is negative, the flip is parked and `flip_deferred` rises. If d ≥ SAFE_US, the flip goes to the shadow pair at once.
- R6: At the next end-of-frame, a parked flip is moved to the shadow pair and `flip_deferred` clears. No `done_evt` is given at that end-of-frame. The event stays open and is signalled at the end-of-frame after it.
- R7: An end-of-frame with no parked flip and an open event gives exactly one cycle of `done_evt` and clears `evt_pending`. Every end-of-frame records `us_now` as the new timestamp.
- R8: While `evt_pending` is 1, `req_ready` is 0 and `req_busy` equals `req_valid`. A refused request does not change the shadow pair or the parked flip.
- R9: While `enable` is 0, the unit clears the parked flip, the shadow pair, the open event and the timestamp. After re-enabling, the next frame start yields 0, and the next flip is applied at once.
- R10: `req_ready` is 0 in any cycle where `eof_pulse` is 1 or `enable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Unit enable; low clears all held state |
| us_now | input | 32 | Free-running microsecond time base |
| refresh_hz | input | 8 | Refresh rate in Hz; 0 disables the safety window |
| eof_pulse | input | 1 | End-of-frame pulse |
| frame_start | input | 1 | Frame-start pulse; latches the shadow pair to the output |
| req_valid | input | 1 | Flip request valid |
| req_ready | output | 1 | Flip request accepted this cycle if valid |
| req_busy | output | 1 | Flip request refused, event still open |
| req_base | input | 32 | Buffer base address |
| req_plane_off | input | 32 | Plane offset in bytes |
| req_pitch | input | 16 | Line pitch in bytes |
| req_x | input | 12 | Horizontal pan in pixels |
| req_y | input | 12 | Vertical pan in lines |
| req_bpp | input | 3 | Bytes per pixel |
| req_lines | input | 12 | Active line count |
| dma_pair | output | 64 | {ceiling, start} seen by the fetch engine |
| done_evt | output | 1 | One-cycle completion event pulse |
| evt_pending | output | 1 | Completion event open |
| flip_deferred | output | 1 | A parked flip waits for end-of-frame |

## Verification
The bench uses four buffer descriptions with 1, 2, 3 and 4 bytes per pixel and different pitches, pans and line counts, so that a swapped term or a wrong multiplier in the address arithmetic shows up in at least one of them. It places flips at several distances from the predicted blank: before any timestamp exists, far from the blank, exactly SAFE_US before it, one microsecond inside the window, past the blank, and with a zero refresh rate. These separate an off-by-one or unsigned comparison from a correct one. A flip attempted while an event is open, and a disable while a flip is parked, show whether the refusal and the clearing leave the output pair and the event state as required.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int ADDR_W     = 32;
    localparam int DIM_W      = 12;
    localparam int PITCH_W    = 16;
    localparam int BPP_W      = 3;
    localparam int TIME_W     = 32;
    localparam int RATE_W     = 8;
    localparam int US_PER_SEC = 1000000;
    localparam int PAIR_W     = 2 * ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  plane_off;
        logic [PITCH_W-1:0] pitch;
        logic [DIM_W-1:0]   pan_x;
        logic [DIM_W-1:0]   pan_y;
        logic [BPP_W-1:0]   bpp;
        logic [DIM_W-1:0]   lines;
    } flip_req_t;

    // ceiling occupies the upper half, start the lower half
    typedef struct packed {
        logic [ADDR_W-1:0] ceil;
        logic [ADDR_W-1:0] start;
    } addr_pair_t;

    function automatic logic [TIME_W-1:0] frame_period_us(input logic [RATE_W-1:0] hz);
        if (hz == '0) return '0;
        return TIME_W'(US_PER_SEC) / TIME_W'(hz);
    endfunction
endpackage

// File: rtl/scan_addr_calc.sv
module scan_addr_calc
    import scan_pkg::*;
#(
    parameter bit CEIL_LAST_BYTE = 1'b1
) (
    input  flip_req_t  req,
    output addr_pair_t pair
);
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_off;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] start_a;
    logic [ADDR_W-1:0] end_a;

    always_comb begin
        row_off = ADDR_W'(req.pan_y) * ADDR_W'(req.pitch);
        col_off = ADDR_W'(req.pan_x) * ADDR_W'(req.bpp);
        span    = ADDR_W'(req.lines) * ADDR_W'(req.pitch);
        start_a = req.base + req.plane_off + row_off + col_off;
        end_a   = start_a + span;
    end

    assign pair.start = start_a;

    generate
        if (CEIL_LAST_BYTE) begin : g_last_byte
            assign pair.ceil = end_a - ADDR_W'(1);
        end else begin : g_past_end
            assign pair.ceil = end_a;
        end
    endgenerate
endmodule

// File: rtl/scan_vblank_guard.sv
module scan_vblank_guard
    import scan_pkg::*;
#(
    parameter int SAFE_US = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              eof_pulse,
    input  logic [TIME_W-1:0] us_now,
    input  logic [RATE_W-1:0] refresh_hz,
    output logic              too_close
);
    logic [TIME_W-1:0]        last_ts;
    logic [TIME_W-1:0]        next_vb;
    logic signed [TIME_W-1:0] slack;

    always_ff @(posedge clk) begin
        if (rst || !enable)
            last_ts <= '0;
        else if (eof_pulse)
            last_ts <= us_now;
    end

    always_comb begin
        next_vb   = last_ts + frame_period_us(refresh_hz);
        slack     = $signed(next_vb - us_now);
        too_close = (last_ts != '0) && (refresh_hz != '0) &&
                    (slack < $signed(TIME_W'(SAFE_US)));
    end
endmodule

// File: rtl/scan_flip_ctrl.sv
module scan_flip_ctrl
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       eof_pulse,
    input  logic       frame_start,
    input  logic       req_valid,
    input  logic       too_close,
    input  addr_pair_t new_pair,
    output logic       req_ready,
    output logic       req_busy,
    output addr_pair_t out_pair,
    output logic       done_evt,
    output logic       evt_pending,
    output logic       flip_deferred
);
    addr_pair_t shadow_q;
    addr_pair_t park_q;
    logic       park_v;
    logic       evt_q;
    logic       done_q;
    logic       accept;

    assign req_ready = enable && !evt_q && !eof_pulse;
    assign req_busy  = req_valid && evt_q;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            shadow_q <= '0;
            park_q   <= '0;
            park_v   <= 1'b0;
            evt_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                evt_q <= 1'b1;
                if (too_close) begin
                    park_q <= new_pair;
                    park_v <= 1'b1;
                end else begin
                    shadow_q <= new_pair;
                end
            end else if (eof_pulse) begin
                if (park_v) begin
                    shadow_q <= park_q;
                    park_v   <= 1'b0;
                end else if (evt_q) begin
                    evt_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // the fetch side sees the whole pair change at once, only at frame start
    always_ff @(posedge clk) begin
        if (rst)
            out_pair <= '0;
        else if (enable && frame_start)
            out_pair <= shadow_q;
    end

    assign done_evt      = done_q;
    assign evt_pending   = evt_q;
    assign flip_deferred = park_v;
endmodule

// File: rtl/scanout_commit.sv
module scanout_commit
    import scan_pkg::*;
#(
    parameter int SAFE_US        = 1000,
    parameter bit CEIL_LAST_BYTE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [TIME_W-1:0]   us_now,
    input  logic [RATE_W-1:0]   refresh_hz,
    input  logic                eof_pulse,
    input  logic                frame_start,
    input  logic                req_valid,
    output logic                req_ready,
    output logic                req_busy,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [ADDR_W-1:0]   req_plane_off,
    input  logic [PITCH_W-1:0]  req_pitch,
    input  logic [DIM_W-1:0]    req_x,
    input  logic [DIM_W-1:0]    req_y,
    input  logic [BPP_W-1:0]    req_bpp,
    input  logic [DIM_W-1:0]    req_lines,
    output logic [PAIR_W-1:0]   dma_pair,
    output logic                done_evt,
    output logic                evt_pending,
    output logic                flip_deferred
);
    flip_req_t  req;
    addr_pair_t calc_pair;
    addr_pair_t out_pair;
    logic       too_close;

    always_comb begin
        req.base      = req_base;
        req.plane_off = req_plane_off;
        req.pitch     = req_pitch;
        req.pan_x     = req_x;
        req.pan_y     = req_y;
        req.bpp       = req_bpp;
        req.lines     = req_lines;
    end

    scan_addr_calc #(.CEIL_LAST_BYTE(CEIL_LAST_BYTE)) u_calc (
        .req  (req),
        .pair (calc_pair)
    );

    scan_vblank_guard #(.SAFE_US(SAFE_US)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .eof_pulse  (eof_pulse),
        .us_now     (us_now),
        .refresh_hz (refresh_hz),
        .too_close  (too_close)
    );

    scan_flip_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .eof_pulse     (eof_pulse),
        .frame_start   (frame_start),
        .req_valid     (req_valid),
        .too_close     (too_close),
        .new_pair      (calc_pair),
        .req_ready     (req_ready),
        .req_busy      (req_busy),
        .out_pair      (out_pair),
        .done_evt      (done_evt),
        .evt_pending   (evt_pending),
        .flip_deferred (flip_deferred)
    );

    assign dma_pair = out_pair;
endmodule

// File: rtl/scanout_commit_chk.sv
module scanout_commit_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        eof_pulse,
    input logic        frame_start,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_busy,
    input logic [63:0] dma_pair,
    input logic        done_evt,
    input logic        evt_pending,
    input logic        flip_deferred
);
    // R3: output pair moves only after an enabled frame start
    a_r3_pair_hold: assert property (@(posedge clk) disable iff (rst)
        !(enable && frame_start) |=> $stable(dma_pair));

    // R8: an open event blocks acceptance
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        evt_pending |-> !req_ready);

    // R8: busy and ready never together
    a_r8_busy_excl: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && req_busy));

    // R7: a completion pulse closes an event that was open
    a_r7_done_closes: assert property (@(posedge clk) disable iff (rst)
        $rose(done_evt) |-> $past(evt_pending) && !evt_pending);

    // R6: a parked flip always belongs to an open event
    a_r6_park_has_evt: assert property (@(posedge clk) disable iff (rst)
        flip_deferred |-> evt_pending);

    // R9: disabling drops the parked flip and the event
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !flip_deferred && !evt_pending && !done_evt);

    // R10: no acceptance on an end-of-frame cycle
    a_r10_eof_not_ready: assert property (@(posedge clk) disable iff (rst)
        eof_pulse |-> !req_ready);
endmodule

bind scanout_commit scanout_commit_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .eof_pulse     (eof_pulse),
    .frame_start   (frame_start),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_busy      (req_busy),
    .dma_pair      (dma_pair),
    .done_evt      (done_evt),
    .evt_pending   (evt_pending),
    .flip_deferred (flip_deferred)
);

// File: tb/scanout_commit_tb.sv
module scanout_commit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic [31:0] us_now = '0;
    logic [7:0]  refresh_hz = 8'd60;
    logic        eof_pulse = 1'b0;
    logic        frame_start = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready, req_busy;
    logic [31:0] req_base = '0, req_plane_off = '0;
    logic [15:0] req_pitch = '0;
    logic [11:0] req_x = '0, req_y = '0, req_lines = '0;
    logic [2:0]  req_bpp = '0;
    logic [63:0] dma_pair;
    logic        done_evt, evt_pending, flip_deferred;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;
    logic [63:0] pa, pb, pc, pd;

    always #5 clk = ~clk;

    scanout_commit u_dut (
        .clk(clk), .rst(rst), .enable(enable), .us_now(us_now),
        .refresh_hz(refresh_hz), .eof_pulse(eof_pulse), .frame_start(frame_start),
        .req_valid(req_valid), .req_ready(req_ready), .req_busy(req_busy),
        .req_base(req_base), .req_plane_off(req_plane_off), .req_pitch(req_pitch),
        .req_x(req_x), .req_y(req_y), .req_bpp(req_bpp), .req_lines(req_lines),
        .dma_pair(dma_pair), .done_evt(done_evt), .evt_pending(evt_pending),
        .flip_deferred(flip_deferred)
    );

    function automatic logic [63:0] exp_pair(input logic [31:0] b, input logic [31:0] o,
            input logic [15:0] p, input logic [11:0] x, input logic [11:0] y,
            input logic [2:0] bpp, input logic [11:0] l);
        logic [31:0] s, e;
        s = b + o + 32'(y) * 32'(p) + 32'(x) * 32'(bpp);
        e = s + 32'(l) * 32'(p) - 32'd1;
        return {e, s};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // buffer descriptions: 0..3
    task automatic load_req(input int k);
        case (k)
            0: begin req_base = 32'h8000_0000; req_plane_off = 32'h40; req_pitch = 16'd2560;
                     req_x = 12'd8; req_y = 12'd2; req_bpp = 3'd4; req_lines = 12'd480; end
            1: begin req_base = 32'h9000_0000; req_plane_off = 32'h0; req_pitch = 16'd1600;
                     req_x = 12'd100; req_y = 12'd30; req_bpp = 3'd2; req_lines = 12'd600; end
            2: begin req_base = 32'hA000_0000; req_plane_off = 32'h1000; req_pitch = 16'd3072;
                     req_x = 12'd17; req_y = 12'd5; req_bpp = 3'd3; req_lines = 12'd768; end
            default: begin req_base = 32'hB000_0000; req_plane_off = 32'h20; req_pitch = 16'd64;
                     req_x = 12'd1; req_y = 12'd1; req_bpp = 3'd1; req_lines = 12'd2047; end
        endcase
    endtask

    task automatic flip(input int k, input logic [31:0] now, output bit rdy, output bit bsy);
        @(negedge clk);
        load_req(k);
        us_now = now;
        req_valid = 1'b1;
        #1;
        rdy = req_ready;
        bsy = req_busy;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic eof(input logic [31:0] now, output bit rdy_during);
        @(negedge clk);
        us_now = now;
        eof_pulse = 1'b1;
        #1;
        rdy_during = req_ready;
        @(negedge clk);
        eof_pulse = 1'b0;
    endtask

    task automatic fstart;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset;
        check("R3 reset pair", dma_pair, 64'h0);
        check("R8 reset ready", 64'(req_ready), 64'h1);
        check("R7 reset event", 64'(evt_pending), 64'h0);
        check("R6 reset deferred", 64'(flip_deferred), 64'h0);
    endtask

    task automatic t_immediate;
        bit r, b;
        flip(0, 32'd500, r, b);
        check("R4 no timestamp accepted", 64'(r), 64'h1);
        check("R4 no timestamp not deferred", 64'(flip_deferred), 64'h0);
        check("R3 pair waits for frame start", dma_pair, 64'h0);
        fstart();
        check("R1 R2 pair A", dma_pair, pa);
    endtask

    task automatic t_busy;
        bit r, b;
        flip(1, 32'd700, r, b);
        check("R8 ready while open", 64'(r), 64'h0);
        check("R8 busy while open", 64'(b), 64'h1);
        fstart();
        check("R8 refused flip ignored", dma_pair, pa);
        check("R8 refused no park", 64'(flip_deferred), 64'h0);
    endtask

    task automatic t_done;
        bit rd;
        eof(32'd10000, rd);
        check("R10 not ready during eof", 64'(rd), 64'h0);
        check("R7 done pulse", 64'(done_evt), 64'h1);
        check("R7 event closed", 64'(evt_pending), 64'h0);
        @(negedge clk);
        check("R7 single pulse", 64'(done_evt), 64'h0);
    endtask

    task automatic t_far;
        bit r, b, rd;
        flip(1, 32'd12000, r, b);  // next blank 26666
        check("R5 far flip immediate", 64'(flip_deferred), 64'h0);
        fstart();
        check("R1 R2 pair B", dma_pair, pb);
        eof(32'd26666, rd);
        check("R7 done after far flip", 64'(done_evt), 64'h1);
    endtask

    task automatic t_close;
        bit r, b, rd;
        flip(2, 32'd42333, r, b);  // next blank 43332, slack 999
        check("R5 inside window parked", 64'(flip_deferred), 64'h1);
        fstart();
        check("R5 parked not in pair", dma_pair, pb);
        eof(32'd43332, rd);
        check("R6 no done on apply", 64'(done_evt), 64'h0);
        check("R6 park cleared", 64'(flip_deferred), 64'h0);
        check("R6 event still open", 64'(evt_pending), 64'h1);
        fstart();
        check("R6 R1 R2 pair C", dma_pair, pc);
        eof(32'd60000, rd);
        check("R6 done next frame", 64'(done_evt), 64'h1);
    endtask

    task automatic t_boundary;
        bit r, b, rd;
        flip(3, 32'd75666, r, b);  // next 76666, slack exactly 1000
        check("R5 slack equal window immediate", 64'(flip_deferred), 64'h0);
        fstart();
        check("R1 R2 pair D", dma_pair, pd);
        eof(32'd76666, rd);
        check("R7 done boundary", 64'(done_evt), 64'h1);
    endtask

    task automatic t_late;
        bit r, b, rd;
        flip(0, 32'd95000, r, b);  // next 93332, slack negative
        check("R5 past blank parked", 64'(flip_deferred), 64'h1);
        eof(32'd95000, rd);
        fstart();
        check("R6 late flip applied", dma_pair, pa);
        eof(32'd111000, rd);
        check("R6 late done", 64'(done_evt), 64'h1);
    endtask

    task automatic t_rate0;
        bit r, b, rd;
        refresh_hz = 8'd0;
        flip(1, 32'd111500, r, b);
        check("R4 zero rate immediate", 64'(flip_deferred), 64'h0);
        fstart();
        check("R4 zero rate pair", dma_pair, pb);
        eof(32'd120000, rd);
        refresh_hz = 8'd60;
    endtask

    task automatic t_disable;
        bit r, b;
        flip(2, 32'd136500, r, b);  // next 136666 -> parked
        check("R9 setup parked", 64'(flip_deferred), 64'h1);
        @(negedge clk);
        enable = 1'b0;
        #1;
        check("R10 not ready when disabled", 64'(req_ready), 64'h0);
        @(negedge clk);
        check("R9 park cleared", 64'(flip_deferred), 64'h0);
        check("R9 event cleared", 64'(evt_pending), 64'h0);
        enable = 1'b1;
        fstart();
        check("R9 shadow cleared", dma_pair, 64'h0);
        flip(3, 32'd136600, r, b);
        check("R9 timestamp cleared flip immediate", 64'(flip_deferred), 64'h0);
        fstart();
        check("R9 pair after reenable", dma_pair, pd);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        pa = exp_pair(32'h8000_0000, 32'h40, 16'd2560, 12'd8, 12'd2, 3'd4, 12'd480);
        pb = exp_pair(32'h9000_0000, 32'h0, 16'd1600, 12'd100, 12'd30, 3'd2, 12'd600);
        pc = exp_pair(32'hA000_0000, 32'h1000, 16'd3072, 12'd17, 12'd5, 3'd3, 12'd768);
        pd = exp_pair(32'hB000_0000, 32'h20, 16'd64, 12'd1, 12'd1, 3'd1, 12'd2047);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_busy();
        t_done();
        t_far();
        t_close();
        t_boundary();
        t_late();
        t_rate0();
        t_disable();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule